// File: doc/BRIEF.md
# Byte-Wide SPI Master with Realigned Serial Clock

This block is a single-byte SPI master. Software writes one byte into the data register; the block shifts it out most significant bit first on `sdo` while it shifts a byte in from `sdi`. When the eighth bit has been taken in, the received byte replaces the register contents and two flags are raised: one that says the buffer holds unread data, and an interrupt flag. Writing during a transfer does not disturb it. Such a write only raises a sticky collision flag.

The serial clock runs from one of two sources. The first is a fixed divide of the system clock, with a half period of `SYS_DIV/2` cycles. The second toggles once per tick of an external periodic timer, so SCK runs at half the tick rate. The divider is held at zero while the block is idle and starts counting on the load. In tick mode the first tick after a load only aligns the phase. As a result the first SCK pulse of every byte is as wide as the others. SCK is the idle level XOR a registered phase bit, and that phase bit is zero whenever no transfer runs. Enabling or disabling the block therefore never produces a pulse at the idle level.

Top module: `spi_byte_master`

## Requirements
- R1: After reset `busy`, `buf_full`, `irq_flag`, `wcol`, `sdo` and `rd_data` are 0, and `sclk` equals `cpol`.
- R2: A byte written with `wr_en` while enabled and idle produces exactly 16 SCK transitions and 8 bits. The bits go out MSB first on `sdo`, and `sdi` is shifted in MSB first.
- R3: With `cke`=0, `sdo` changes on the idle-to-active SCK transition and `sdi` is sampled on the active-to-idle transition. With `cke`=1 the two roles swap, and the MSB is on `sdo` from the load onward.
- R4: With `clk_src`=0, every SCK half period is exactly `SYS_DIV/2` system clocks, including the first one after the load.
- R5: With `clk_src`=1, SCK toggles on each `tick` pulse except the first tick after the load. Every half period after the first therefore equals the tick interval, and the first one is no shorter than it.
- R6: At completion, `busy` falls, `buf_full` and `irq_flag` are set in the same cycle, and `rd_data` shows the received byte.
- R7: A `wr_en` while `busy` sets `wcol`. The write is discarded: the running byte completes unchanged and no second transfer follows.
- R8: `wcol` stays set until a `wcol_clr` pulse.
- R9: A write in the first cycle after `busy` falls is accepted: `busy` rises and `wcol` stays 0.
- R10: `rd_en` clears `buf_full` and leaves `irq_flag` alone. `irq_flag` clears only on `irq_clr`. A completion in the same cycle as a clear wins.
- R11: While no transfer runs, `sclk` equals `cpol`, also across enable and disable. Dropping `en` aborts a transfer without setting flags, and writes while disabled are ignored without setting `wcol`.
- R12: While idle, `sdo` holds the last bit it drove (bit 0 of the previous byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low aborts and idles |
| cpol | input | 1 | SCK idle level |
| cke | input | 1 | Edge select for data change versus sample |
| clk_src | input | 1 | 0: fixed system divide, 1: timer tick |
| tick | input | 1 | Periodic timer match pulse |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Read strobe, clears buffer-full |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| wcol_clr | input | 1 | Clear of the collision flag |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| rd_data | output | DATA_W | Last received byte |
| buf_full | output | 1 | Received byte not yet read |
| irq_flag | output | 1 | Transfer-complete flag |
| wcol | output | 1 | Sticky write-collision flag |

## Verification
Random bytes are shifted in both edge modes. A behavioural slave on the bench drives `sdi` to match the selected edge mode, so a byte that comes back wrong points to a wrong sample edge or a wrong bit order. In divide mode every SCK segment is measured. In tick mode the tick interval is varied and the load falls at a random point against the tick train, which exposes a first pulse that is too short, because the width of that first segment then depends on where the load landed. Directed cases cover a write during a transfer, a write right after completion, an abort through `en`, writes while disabled, and enable toggling with the clock idling high.

// File: rtl/spi_pkg.sv
package spi_pkg;

    typedef enum logic {
        SRC_DIV  = 1'b0,
        SRC_TICK = 1'b1
    } sck_src_e;

    typedef struct packed {
        logic full;
        logic irq;
        logic wcol;
    } spi_flags_t;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_pkg::*;
#(
    parameter int HALF_DIV = 32
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  sck_src_e src,
    input  logic     tick,
    output logic     strobe
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LIM = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } rate_t;

    rate_t rate_d, rate_q;

    always_comb begin
        rate_d = rate_q;
        strobe = 1'b0;
        if (!run) begin
            rate_d.cnt   = '0;
            rate_d.armed = 1'b0;
        end else if (src == SRC_TICK) begin
            if (tick) begin
                if (rate_q.armed) strobe = 1'b1;
                else              rate_d.armed = 1'b1;
            end
        end else begin
            if (rate_q.cnt == LIM) begin
                strobe     = 1'b1;
                rate_d.cnt = '0;
            end else begin
                rate_d.cnt = rate_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rate_q <= '0;
        else        rate_q <= rate_d;
    end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cke,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              strobe,
    input  logic              sdi,
    output logic              busy,
    output logic              phase,
    output logic              sdo,
    output logic              done,
    output logic [DATA_W-1:0] rx_next
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic              sdo;
        logic [EDGE_W-1:0] edges;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } core_t;

    core_t core_d, core_q;
    logic  lead, final_edge, drive, sample;

    always_comb begin
        core_d     = core_q;
        done       = 1'b0;
        lead       = (core_q.edges[0] == 1'b0);
        final_edge = (core_q.edges == LAST_EDGE);
        drive      = cke ? (!lead && !final_edge) : lead;
        sample     = cke ? lead : !lead;
        if (!en) begin
            core_d.busy  = 1'b0;
            core_d.phase = 1'b0;
            core_d.edges = '0;
        end else if (load) begin
            core_d.busy  = 1'b1;
            core_d.phase = 1'b0;
            core_d.edges = '0;
            core_d.rx    = '0;
            if (cke) begin
                core_d.sdo = load_data[DATA_W-1];
                core_d.tx  = {load_data[DATA_W-2:0], 1'b0};
            end else begin
                core_d.tx  = load_data;
            end
        end else if (core_q.busy && strobe) begin
            core_d.phase = ~core_q.phase;
            core_d.edges = core_q.edges + 1'b1;
            if (drive) begin
                core_d.sdo = core_q.tx[DATA_W-1];
                core_d.tx  = {core_q.tx[DATA_W-2:0], 1'b0};
            end
            if (sample) core_d.rx = {core_q.rx[DATA_W-2:0], sdi};
            if (final_edge) begin
                core_d.busy  = 1'b0;
                core_d.phase = 1'b0;
                core_d.edges = '0;
                done         = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign busy    = core_q.busy;
    assign phase   = core_q.phase;
    assign sdo     = core_q.sdo;
    assign rx_next = core_d.rx;

endmodule

// File: rtl/spi_flag_regs.sv
module spi_flag_regs
    import spi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_in,
    input  logic              rd_en,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    input  logic              collide,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              irq_flag,
    output logic              wcol
);
    typedef struct packed {
        logic [DATA_W-1:0] rx_buf;
        spi_flags_t        f;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en)    st_d.f.full = 1'b0;
        if (irq_clr)  st_d.f.irq  = 1'b0;
        if (wcol_clr) st_d.f.wcol = 1'b0;
        if (collide)  st_d.f.wcol = 1'b1;
        if (done) begin
            st_d.rx_buf = rx_in;
            st_d.f.full = 1'b1;
            st_d.f.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.rx_buf;
    assign buf_full = st_q.f.full;
    assign irq_flag = st_q.f.irq;
    assign wcol     = st_q.f.wcol;

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SYS_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic              cke,
    input  logic              clk_src,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              irq_flag,
    output logic              wcol
);
    localparam int HALF_DIV = SYS_DIV / 2;

    sck_src_e          src_sel;
    logic              accept, collide, strobe, phase, done;
    logic [DATA_W-1:0] rx_next;

    assign src_sel = clk_src ? SRC_TICK : SRC_DIV;
    assign accept  = en & wr_en & ~busy;
    assign collide = en & wr_en & busy;

    spi_rate_gen #(.HALF_DIV(HALF_DIV)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .src    (src_sel),
        .tick   (tick),
        .strobe (strobe)
    );

    spi_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cke       (cke),
        .load      (accept),
        .load_data (wr_data),
        .strobe    (strobe),
        .sdi       (sdi),
        .busy      (busy),
        .phase     (phase),
        .sdo       (sdo),
        .done      (done),
        .rx_next   (rx_next)
    );

    spi_flag_regs #(.DATA_W(DATA_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .rx_in    (rx_next),
        .rd_en    (rd_en),
        .irq_clr  (irq_clr),
        .wcol_clr (wcol_clr),
        .collide  (collide),
        .rd_data  (rd_data),
        .buf_full (buf_full),
        .irq_flag (irq_flag),
        .wcol     (wcol)
    );

    assign sclk = cpol ^ phase;

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cpol,
    input logic wr_en,
    input logic rd_en,
    input logic irq_clr,
    input logic wcol_clr,
    input logic sclk,
    input logic sdo,
    input logic busy,
    input logic buf_full,
    input logic irq_flag,
    input logic wcol
);
    p_idle_sck_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    p_collision_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en && busy) |=> wcol);

    p_wcol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol && !wcol_clr) |=> wcol);

    p_done_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(en)) |-> (buf_full && irq_flag));

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en && !busy && !wcol) |=> (busy && !wcol));

    p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy) |=> !buf_full);

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    p_sdo_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(sdo));

endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cpol     (cpol),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .irq_clr  (irq_clr),
    .wcol_clr (wcol_clr),
    .sclk     (sclk),
    .sdo      (sdo),
    .busy     (busy),
    .buf_full (buf_full),
    .irq_flag (irq_flag),
    .wcol     (wcol)
);

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
    localparam int HALF = 32;

    logic clk = 1'b0;
    logic rst_n, en, cpol, cke, clk_src, tick, wr_en, rd_en, irq_clr, wcol_clr, sdi;
    logic [7:0] wr_data, rd_data;
    logic sclk, sdo, busy, buf_full, irq_flag, wcol;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // bench slave and monitor state
    logic [7:0] slv_b = 8'h00;
    logic       cke_b = 1'b0;
    int         ec = 0;
    int         tp = 4, tcnt = 0;
    logic       last_sclk = 1'b0, last_busy = 1'b0, prev_sdo = 1'b0;
    int         seg = 0, nseg = 0, first_seg = 0, seg_min = 0, seg_max = 0, idle_bad = 0;
    logic [7:0] tx_seen = 8'h00;
    logic [7:0] exp_tx = 8'h00;
    logic       exp_src = 1'b0;

    always #2.5 clk = ~clk;

    spi_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cke(cke), .clk_src(clk_src),
        .tick(tick), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .irq_clr(irq_clr),
        .wcol_clr(wcol_clr), .sdi(sdi), .sclk(sclk), .sdo(sdo), .busy(busy),
        .rd_data(rd_data), .buf_full(buf_full), .irq_flag(irq_flag), .wcol(wcol)
    );

    function automatic int bitpos(input int e, input logic k);
        int b;
        b = k ? e / 2 : ((e == 0) ? 0 : (e - 1) / 2);
        if (b > 7) b = 7;
        return b;
    endfunction

    function automatic int exp_half(input logic src, input int t);
        return src ? t : HALF;
    endfunction

    function automatic logic is_sample(input int e, input logic k);
        return k ? (e % 2 == 0) : (e % 2 == 1);
    endfunction

    assign sdi = slv_b[7 - bitpos(ec, cke_b)];

    // timer tick source
    initial begin
        tick = 1'b0;
        forever begin
            @(negedge clk);
            if (tcnt >= tp) tcnt = 0;
            tick = (tcnt == 0);
            tcnt = tcnt + 1;
        end
    end

    // monitor: values seen at a posedge are those of the cycle just ended
    always @(posedge clk) begin
        if (rst_n) begin
            if (busy && !last_busy) begin
                seg = 1; nseg = 0; first_seg = 0; seg_min = 100000; seg_max = 0;
                tx_seen = 8'h00;
                ec <= 0;
            end else if (busy || last_busy) begin
                if (sclk != last_sclk) begin
                    if (nseg == 0) first_seg = seg;
                    else begin
                        if (seg < seg_min) seg_min = seg;
                        if (seg > seg_max) seg_max = seg;
                    end
                    nseg = nseg + 1;
                    if (is_sample(ec, cke_b)) tx_seen = {tx_seen[6:0], prev_sdo};
                    ec <= ec + 1;
                    seg = 1;
                end else begin
                    seg = seg + 1;
                end
            end
            if (!busy && sclk != cpol) idle_bad = idle_bad + 1;
        end
        last_sclk = sclk;
        last_busy = busy;
        prev_sdo  = sdo;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [7:0] tx, input logic [7:0] sv, input logic k,
                         input logic src, input int t);
        @(negedge clk);
        cke = k; cke_b = k; clk_src = src; tp = t; slv_b = sv;
        exp_tx = tx; exp_src = src;
        wr_data = tx; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_done();
        chk(tx_seen == exp_tx, exp_src ? "R3 tick sdo bits" : "R2 sdo bits MSB first", tx_seen, exp_tx);
        chk(nseg == 16, "R2 sck transitions", nseg, 16);
        chk(rd_data == slv_b, "R6 received byte", rd_data, slv_b);
        chk(buf_full == 1'b1, "R6 buf_full set", buf_full, 1);
        chk(irq_flag == 1'b1, "R6 irq set", irq_flag, 1);
        chk(sdo == exp_tx[0], "R12 sdo holds last bit", sdo, exp_tx[0]);
        if (!exp_src) begin
            chk(first_seg == exp_half(1'b0, tp), "R4 first half period", first_seg, HALF);
            chk(seg_min == HALF && seg_max == HALF, "R4 half periods", seg_max, HALF);
        end else begin
            chk(first_seg >= exp_half(1'b1, tp), "R5 first half period not short", first_seg, tp);
            chk(seg_min == tp && seg_max == tp, "R5 half periods", seg_min, tp);
        end
    endtask

    task automatic finish_xfer();
        while (busy) @(negedge clk);
        @(negedge clk);
        check_done();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(buf_full == 1'b0, "R10 read clears buf_full", buf_full, 0);
        chk(irq_flag == 1'b1, "R10 read keeps irq", irq_flag, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq_flag == 1'b0, "R10 irq_clr clears irq", irq_flag, 0);
        chk(sdo == exp_tx[0], "R12 sdo still held", sdo, exp_tx[0]);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd8812);
        rst_n = 1'b0; en = 1'b0; cpol = 1'b0; cke = 1'b0; clk_src = 1'b0;
        wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0; irq_clr = 1'b0; wcol_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && buf_full == 1'b0 && irq_flag == 1'b0 && wcol == 1'b0,
            "R1 flags after reset", {busy, buf_full, irq_flag, wcol}, 0);
        chk(sdo == 1'b0 && rd_data == 8'h00, "R1 data after reset", rd_data, 0);
        chk(sclk == cpol, "R1 sclk idle", sclk, cpol);
        en = 1'b1;

        // directed: both edge modes, both sources
        start(8'hA5, 8'h3C, 1'b0, 1'b0, 4); finish_xfer();
        start(8'h81, 8'h7E, 1'b1, 1'b0, 4); finish_xfer();
        start(8'h5A, 8'hC3, 1'b0, 1'b1, 5); finish_xfer();
        start(8'h0F, 8'hF0, 1'b1, 1'b1, 3); finish_xfer();

        // random mix
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            cpol = 1'(($urandom % 2));
            repeat ($urandom % 7) @(negedge clk);
            start(8'($urandom), 8'($urandom), 1'($urandom % 2), 1'($urandom % 2),
                  3 + int'($urandom % 6));
            finish_xfer();
        end

        // R9: write in the first idle cycle after completion
        start(8'hC6, 8'h19, 1'b0, 1'b0, 4);
        while (busy) @(negedge clk);
        wr_data = 8'h3B; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy == 1'b1, "R9 immediate write accepted", busy, 1);
        chk(wcol == 1'b0, "R9 no collision", wcol, 0);
        chk(tx_seen == 8'hC6, "R9 first byte intact", tx_seen, 8'hC6);
        exp_tx = 8'h3B;
        finish_xfer();

        // R7: write during transfer
        start(8'h96, 8'h55, 1'b1, 1'b0, 4);
        repeat (100) @(negedge clk);
        wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(wcol == 1'b1, "R7 collision flagged", wcol, 1);
        finish_xfer();
        chk(tx_seen == 8'h96, "R7 running byte unchanged", tx_seen, 8'h96);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R7 discarded write not started", busy, 0);

        // R8: sticky across another clean transfer
        start(8'h44, 8'h22, 1'b0, 1'b1, 4); finish_xfer();
        chk(wcol == 1'b1, "R8 wcol sticky", wcol, 1);
        wcol_clr = 1'b1;
        @(negedge clk);
        wcol_clr = 1'b0;
        chk(wcol == 1'b0, "R8 wcol_clr clears", wcol, 0);

        // R11: enable toggling with idle-high clock
        cpol = 1'b1;
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            en = ~en;
            @(negedge clk);
            chk(sclk == 1'b1, "R11 sclk idle across enable change", sclk, 1);
        end
        en = 1'b1;

        // R11: abort by disable
        start(8'hE7, 8'h18, 1'b0, 1'b0, 4);
        repeat (40) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R11 abort clears busy", busy, 1);
        chk(sclk == 1'b1, "R11 abort returns sclk idle", sclk, 1);
        repeat (3) @(negedge clk);
        chk(irq_flag == 1'b0 && buf_full == 1'b0, "R11 abort sets no flags",
            {irq_flag, buf_full}, 0);

        // R11: write while disabled ignored
        wr_data = 8'hAA; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && wcol == 1'b0, "R11 disabled write ignored", {busy, wcol}, 0);
        chk(idle_bad == 0, "R11 idle sclk never off idle level", idle_bad, 0);
        en = 1'b1;

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk = n_chk + 1;
            n_err = n_err + 1;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule